// File: doc/BRIEF.md
# Data-Ready Flag with Read Interlock

This block produces a one-bit data-ready status flag for a sensor front end. The flag rises when the conversion engine reports a new sample. A host register read that targets the output-data address ranges clears the flag when the read begins and holds it low until the read ends. The host therefore never sees the flag set while it is in the middle of collecting a half-updated set of data registers.

A sample that arrives while such a read is open is not lost. A one-bit pending register remembers it, and the flag rises on the cycle after the read-complete pulse. Reads of any other address go straight through the block, with no effect on the flag. The serial bus and the data registers themselves sit outside this block. It sees only a read-start pulse, a read-complete pulse and the address of the read.

Top module: `drdy_flag`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `data_ready` is 0 and no read is open.
- R2: With no protected read open, a `new_sample` pulse makes `data_ready` 1 on the following cycle. The flag stays 1 until a protected read starts.
- R3: A read counts as protected only when `rd_addr` lies in 0x08–0x0A or in 0x0E–0x15, ends included. Addresses 0x07, 0x0B, 0x0D and 0x16 are not protected.
- R4: A `rd_start` pulse with a protected address and no read open forces `data_ready` to 0 on the next cycle.
- R5: From a protected start until its `rd_done`, `data_ready` stays 0, whatever `new_sample` does.
- R6: If the flag was 0 before a protected read and a sample arrives during that read, `data_ready` becomes 1 on the cycle after `rd_done`.
- R7: If the flag was 1 before a protected read and a sample arrives during that read, the flag reads 0 for the whole read and 1 on the cycle after `rd_done`.
- R8: If no sample arrives during a protected read, `data_ready` stays 0 after `rd_done`.
- R9: A read with an unprotected address neither clears nor freezes the flag: a sample during it still sets `data_ready`.
- R10: Any number of samples during one protected read produce a single set. A following protected read with no new sample leaves the flag 0.
- R11: A sample in the same cycle as a protected `rd_start`, or in the same cycle as the closing `rd_done`, counts as arriving during the read.
- R12: A `rd_start` while a protected read is open is ignored. A `rd_done` with no protected read open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| new_sample | input | 1 | One-cycle pulse: the conversion engine has a new sample |
| rd_start | input | 1 | One-cycle pulse: a host register read begins |
| rd_done | input | 1 | One-cycle pulse: the current host register read ends |
| rd_addr | input | ADDR_W (8) | Register address, sampled with `rd_start` |
| data_ready | output | 1 | Data-ready status flag |

## Verification
The properties assume that `rd_start`, `rd_done` and `new_sample` are single-cycle pulses. They also assume that `rd_addr` is only meaningful in the cycle that carries `rd_start`, and that a start and a done never share a cycle. The stimulus drives each pulse for exactly one cycle, and always separates a start from its done by at least one cycle. Overlapping starts and stray dones are still produced, on purpose, to exercise the ignore rules.

// File: rtl/drdy_pkg.sv
package drdy_pkg;

    localparam int ADDR_W  = 8;
    localparam int NUM_WIN = 2;

    typedef logic [ADDR_W-1:0] addr_t;

    // protected address ranges, inclusive at both ends
    localparam addr_t WIN_LO [NUM_WIN] = '{8'h08, 8'h0E};
    localparam addr_t WIN_HI [NUM_WIN] = '{8'h0A, 8'h15};

    // read-tracker events handed to the flag core
    typedef struct packed {
        logic open;   // accepted protected read start
        logic close;  // completion of the open protected read
        logic busy;   // protected read in progress
    } rd_evt_t;

    // flag core state
    typedef struct packed {
        logic flag;
        logic pend;
    } flag_st_t;

    function automatic logic addr_in(addr_t a, addr_t lo, addr_t hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/drdy_win_decode.sv
module drdy_win_decode
    import drdy_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NW = NUM_WIN
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic [NW-1:0] hits;

    for (genvar i = 0; i < NW; i++) begin : g_win
        assign hits[i] = addr_in(addr, WIN_LO[i], WIN_HI[i]);
    end

    assign hit = |hits;
endmodule

// File: rtl/drdy_read_track.sv
module drdy_read_track
    import drdy_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_prot,
    input  logic    done,
    output rd_evt_t evt
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst)
            busy_q <= 1'b0;
        else if (!busy_q && start_prot)
            busy_q <= 1'b1;
        else if (busy_q && done)
            busy_q <= 1'b0;
    end

    always_comb begin
        evt.open  = start_prot && !busy_q;
        evt.close = done && busy_q;
        evt.busy  = busy_q;
    end
endmodule

// File: rtl/drdy_flag_core.sv
module drdy_flag_core
    import drdy_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rd_evt_t  evt,
    input  logic     sample,
    output flag_st_t st
);
    flag_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (evt.open) begin
            st_d.flag = 1'b0;
            st_d.pend = sample;
        end else if (evt.close) begin
            st_d.flag = st_q.pend || sample;
            st_d.pend = 1'b0;
        end else if (evt.busy) begin
            st_d.pend = st_q.pend || sample;
        end else if (sample) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/drdy_flag.sv
module drdy_flag
    import drdy_pkg::*;
#(
    parameter int ADDR_W = drdy_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              new_sample,
    input  logic              rd_start,
    input  logic              rd_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              data_ready
);
    logic     win_hit;
    rd_evt_t  evt;
    flag_st_t st;

    drdy_win_decode #(.AW(ADDR_W), .NW(NUM_WIN)) u_dec (
        .addr (rd_addr),
        .hit  (win_hit)
    );

    drdy_read_track u_trk (
        .clk        (clk),
        .rst        (rst),
        .start_prot (rd_start && win_hit),
        .done       (rd_done),
        .evt        (evt)
    );

    drdy_flag_core u_core (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .sample (new_sample),
        .st     (st)
    );

    assign data_ready = st.flag;
endmodule

// File: rtl/drdy_flag_chk.sv
module drdy_flag_chk
    import drdy_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  new_sample,
    input logic  rd_start,
    input logic  rd_done,
    input addr_t rd_addr,
    input logic  data_ready,
    input logic  busy,
    input logic  pend
);
    logic prot;
    assign prot = addr_in(rd_addr, 8'h08, 8'h0A) || addr_in(rd_addr, 8'h0E, 8'h15);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!data_ready && !busy));

    assert_idle_set_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && new_sample && !(rd_start && prot)) |=> data_ready);

    assert_start_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && rd_start && prot) |=> (!data_ready && busy));

    assert_frozen_low_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> !data_ready);

    assert_late_set_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_done && (pend || new_sample)) |=> data_ready);

    assert_stay_low_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_done && !pend && !new_sample) |=> !data_ready);

    assert_unprot_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && rd_start && !prot && data_ready) |=> data_ready);

    assert_stray_done_R12: assert property (@(posedge clk) disable iff (rst)
        (!busy && rd_done && !rd_start && data_ready) |=> data_ready);
endmodule

bind drdy_flag drdy_flag_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .new_sample (new_sample),
    .rd_start   (rd_start),
    .rd_done    (rd_done),
    .rd_addr    (rd_addr),
    .data_ready (data_ready),
    .busy       (evt.busy),
    .pend       (st.pend)
);

// File: tb/drdy_flag_test.sv
module drdy_flag_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       new_sample = 1'b0;
    logic       rd_start = 1'b0;
    logic       rd_done = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic       data_ready;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    exp_q[$];
    string tag_q[$];
    bit    finished = 1'b0;

    always #2 clk = ~clk;

    drdy_flag uut (
        .clk        (clk),
        .rst        (rst),
        .new_sample (new_sample),
        .rd_start   (rd_start),
        .rd_done    (rd_done),
        .rd_addr    (rd_addr),
        .data_ready (data_ready)
    );

    // monitor: compares the flag after each edge with the queued expectation
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (data_ready !== e) begin
                n_bad++;
                $display("FAIL %s: data_ready=%0b expected %0b", t, data_ready, e);
            end
        end
    end

    // driver: one cycle of stimulus plus the flag value expected after it
    task automatic step(bit s, bit st, bit dn, logic [7:0] a, bit e, string t);
        @(negedge clk);
        new_sample = s;
        rd_start   = st;
        rd_done    = dn;
        rd_addr    = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(0,0,0,8'h00, 0, "R1 reset state");
        step(1,0,0,8'h00, 1, "R2 idle sample sets");
        step(0,0,0,8'h00, 1, "R2 flag holds");
        // boundary addresses outside the windows
        step(0,1,0,8'h07, 1, "R3 0x07 unprotected");
        step(0,0,1,8'h00, 1, "R3 done after 0x07");
        step(0,1,0,8'h0B, 1, "R3 0x0B unprotected");
        step(0,0,1,8'h00, 1, "R3 done after 0x0B");
        step(0,1,0,8'h0D, 1, "R3 0x0D unprotected");
        step(0,0,1,8'h00, 1, "R3 done after 0x0D");
        step(0,1,0,8'h16, 1, "R3 0x16 unprotected");
        step(0,0,1,8'h00, 1, "R3 done after 0x16");
        // protected read, no sample
        step(0,1,0,8'h08, 0, "R4 start clears at 0x08");
        step(0,0,1,8'h00, 0, "R8 no sample stays low");
        // flag 1 before, several samples during
        step(1,0,0,8'h00, 1, "R2 set again");
        step(0,1,0,8'h15, 0, "R4 start clears at 0x15");
        step(1,0,0,8'h00, 0, "R5 sample during read");
        step(1,0,0,8'h00, 0, "R5 second sample during read");
        step(0,0,0,8'h00, 0, "R5 still frozen");
        step(0,0,1,8'h00, 1, "R7 set after done");
        step(0,1,0,8'h0E, 0, "R10 next read clears at 0x0E");
        step(0,0,1,8'h00, 0, "R10 single set consumed");
        // flag 0 before, sample during
        step(0,1,0,8'h0A, 0, "R6 start at 0x0A");
        step(1,0,0,8'h00, 0, "R6 sample during read");
        step(0,0,1,8'h00, 1, "R6 set after done");
        // same-cycle corners
        step(1,1,0,8'h09, 0, "R11 sample with start");
        step(0,0,1,8'h00, 1, "R11 start-cycle sample kept");
        step(0,1,0,8'h10, 0, "R11 start at 0x10");
        step(1,0,1,8'h00, 1, "R11 sample with done");
        // unprotected read does not clear or freeze
        step(0,1,0,8'h10, 0, "R4 start at 0x10");
        step(0,0,1,8'h00, 0, "R8 empty read");
        step(0,1,0,8'h20, 0, "R9 unprotected start");
        step(1,0,0,8'h00, 1, "R9 sample not frozen");
        step(0,0,1,8'h00, 1, "R9 done no effect");
        // ignored pulses
        step(0,1,0,8'h08, 0, "R12 start");
        step(0,1,0,8'h09, 0, "R12 nested start ignored");
        step(1,0,0,8'h00, 0, "R12 sample during read");
        step(0,0,1,8'h00, 1, "R12 first done closes read");
        step(0,0,1,8'h00, 1, "R12 stray done ignored");
        step(0,0,0,8'h00, 1, "R12 flag kept");
        @(negedge clk);
        new_sample = 1'b0;
        rd_start   = 1'b0;
        rd_done    = 1'b0;
        wait (exp_q.size() == 0);
        @(negedge clk);
        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 2000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: finished=0 expected 1");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule